// File: doc/BRIEF.md
# Activity LED Driver

This block turns a single-cycle activity strobe from an Ethernet datapath into a level that can drive an indicator LED. A strobe lasts one clock, which is too short to see. The block makes each strobe visible in one of four ways. It can pass the strobe through, hold the LED on for a fixed time, blink it at a fast rate, or blink it at a slow rate.

Two enables choose the mode. Each enable is the OR of a strap pin and a register bit. With neither enable set, the LED follows the strobe. Stretch alone holds the LED on after the last activity. Blink alone gives fast on/off phases. When both enables are set, the blink slows to long phases instead of stretching and blinking together. All timing is counted in milliseconds by a prescaler. The prescaler's clocks-per-millisecond parameter can be made small for simulation.

The LED output is registered. It changes on the clock edge that samples the activity or the timer event.

Top module: `led_activity_drv`

## Requirements
- R1: The stretch enable is `str_pin_i` OR `str_reg_i`. Either input alone selects the stretch behaviour when blink is off.
- R2: The blink enable is `blink_pin_i` OR `blink_reg_i`. Either input alone selects the fast blink when stretch is off.
- R3: With both enables low, `led_o` equals `act_i` delayed by one clock.
- R4: In stretch mode, `led_o` rises on the edge that samples `act_i` high. It stays high for exactly HOLD_MS*CLKS_PER_MS clocks after the last sampled activity, then falls.
- R5: In stretch mode, activity during the hold window restarts the full hold count.
- R6: In fast blink mode (blink only), activity seen while idle starts a phase pair. The LED is high for FAST_MS*CLKS_PER_MS clocks, then low for the same length.
- R7: With both enables high, the phases last SLOW_MS*CLKS_PER_MS clocks each (500 ms by default) instead of the fast length.
- R8: In either blink mode, activity seen during a phase pair starts a new pair straight after it. With no such activity, the LED stays low after the low phase until new activity arrives.
- R9: Synchronous reset drives `led_o` low and clears the timers. The first hold after reset lasts the full length.
- R10: A change of mode abandons the running sequence. Without activity, the LED is low one clock after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| act_i | input | 1 | One-cycle activity strobe |
| str_pin_i | input | 1 | Stretch enable strap |
| blink_pin_i | input | 1 | Blink enable strap |
| str_reg_i | input | 1 | Stretch enable register bit |
| blink_reg_i | input | 1 | Blink enable register bit |
| led_o | output | 1 | LED drive level, high = on |

## Verification
The hardest case to reach from the ports is a pending blink pair. Activity has to land inside the high phase of a running pair, and the bench must then see the LED come back on exactly at the end of the low phase rather than go idle. The bench reaches it with a small clocks-per-millisecond value. It places a second strobe a known number of clocks into the first phase and samples at the computed phase boundaries. The retriggered stretch is reached the same way: a second strobe is placed part-way through the hold window, and the fall is checked at the restarted deadline.

// File: rtl/led_act_pkg.sv
package led_act_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT  = 2'd0,
        MODE_STRETCH = 2'd1,
        MODE_FAST    = 2'd2,
        MODE_SLOW    = 2'd3
    } led_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_ON   = 2'd2,
        ST_OFF  = 2'd3
    } led_state_e;

endpackage

// File: rtl/led_act_mode.sv
module led_act_mode
    import led_act_pkg::*;
(
    input  logic      str_pin_i,
    input  logic      blink_pin_i,
    input  logic      str_reg_i,
    input  logic      blink_reg_i,
    output led_mode_e mode_o
);

    logic stretch_en;
    logic blink_en;

    always_comb begin
        stretch_en = str_pin_i | str_reg_i;
        blink_en   = blink_pin_i | blink_reg_i;
        case ({stretch_en, blink_en})
            2'b10:   mode_o = MODE_STRETCH;
            2'b01:   mode_o = MODE_FAST;
            2'b11:   mode_o = MODE_SLOW;
            default: mode_o = MODE_DIRECT;
        endcase
    end

endmodule

// File: rtl/led_act_prescale.sv
module led_act_prescale #(
    parameter int CLKS_PER_MS = 25000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    output logic tick_o
);

    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ps_t;

    ps_t ps_d, ps_q;

    assign tick_o = (ps_q.cnt == LAST);

    always_comb begin
        ps_d = ps_q;
        if (clr_i || tick_o) begin
            ps_d.cnt = '0;
        end else begin
            ps_d.cnt = ps_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    generate
        if (CLKS_PER_MS > 1) begin : g_spacing
            p_tick_spacing_r4: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o)
                else $error("millisecond ticks closer than one period");
        end
    endgenerate

endmodule

// File: rtl/led_act_seq.sv
module led_act_seq
    import led_act_pkg::*;
#(
    parameter int HOLD_MS = 42,
    parameter int FAST_MS = 42,
    parameter int SLOW_MS = 500
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  led_mode_e mode_i,
    input  logic      act_i,
    input  logic      tick_i,
    output logic      clr_o,
    output logic      led_o
);

    localparam int MAX_A  = (HOLD_MS > FAST_MS) ? HOLD_MS : FAST_MS;
    localparam int MAX_MS = (MAX_A > SLOW_MS) ? MAX_A : SLOW_MS;
    localparam int MSW    = $clog2(MAX_MS + 1);
    localparam logic [MSW-1:0] HOLD_LAST = MSW'(HOLD_MS - 1);
    localparam logic [MSW-1:0] FAST_LAST = MSW'(FAST_MS - 1);
    localparam logic [MSW-1:0] SLOW_LAST = MSW'(SLOW_MS - 1);

    typedef struct packed {
        led_state_e     state;
        logic [MSW-1:0] ms;
        logic           led;
        logic           pend;
        led_mode_e      mode;
    } seq_t;

    seq_t           sq_d, sq_q;
    logic           same_mode;
    led_state_e     cur_state;
    logic           cur_pend;
    logic [MSW-1:0] ph_last;

    always_comb begin
        sq_d      = sq_q;
        clr_o     = 1'b0;
        same_mode = (mode_i == sq_q.mode);
        cur_state = same_mode ? sq_q.state : ST_IDLE;
        cur_pend  = same_mode & sq_q.pend;
        ph_last   = (mode_i == MODE_SLOW) ? SLOW_LAST : FAST_LAST;
        sq_d.mode = mode_i;
        if (!same_mode) begin
            clr_o = 1'b1;
        end

        case (mode_i)
            MODE_DIRECT: begin
                sq_d.state = ST_IDLE;
                sq_d.ms    = '0;
                sq_d.pend  = 1'b0;
                sq_d.led   = act_i;
                clr_o      = 1'b1;
            end
            MODE_STRETCH: begin
                sq_d.pend = 1'b0;
                if (act_i) begin
                    sq_d.state = ST_HOLD;
                    sq_d.ms    = '0;
                    sq_d.led   = 1'b1;
                    clr_o      = 1'b1;
                end else if (cur_state == ST_HOLD) begin
                    if (tick_i) begin
                        if (sq_q.ms == HOLD_LAST) begin
                            sq_d.state = ST_IDLE;
                            sq_d.ms    = '0;
                            sq_d.led   = 1'b0;
                        end else begin
                            sq_d.ms = sq_q.ms + 1'b1;
                        end
                    end
                end else begin
                    sq_d.state = ST_IDLE;
                    sq_d.ms    = '0;
                    sq_d.led   = 1'b0;
                end
            end
            default: begin
                case (cur_state)
                    ST_ON: begin
                        sq_d.pend = cur_pend | act_i;
                        if (tick_i) begin
                            if (sq_q.ms == ph_last) begin
                                sq_d.state = ST_OFF;
                                sq_d.ms    = '0;
                                sq_d.led   = 1'b0;
                            end else begin
                                sq_d.ms = sq_q.ms + 1'b1;
                            end
                        end
                    end
                    ST_OFF: begin
                        sq_d.pend = cur_pend | act_i;
                        if (tick_i) begin
                            if (sq_q.ms == ph_last) begin
                                sq_d.ms = '0;
                                if (cur_pend | act_i) begin
                                    sq_d.state = ST_ON;
                                    sq_d.led   = 1'b1;
                                    sq_d.pend  = 1'b0;
                                end else begin
                                    sq_d.state = ST_IDLE;
                                    sq_d.led   = 1'b0;
                                    sq_d.pend  = 1'b0;
                                end
                            end else begin
                                sq_d.ms = sq_q.ms + 1'b1;
                            end
                        end
                    end
                    default: begin
                        sq_d.ms   = '0;
                        sq_d.pend = 1'b0;
                        if (act_i) begin
                            sq_d.state = ST_ON;
                            sq_d.led   = 1'b1;
                            clr_o      = 1'b1;
                        end else begin
                            sq_d.state = ST_IDLE;
                            sq_d.led   = 1'b0;
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sq_q <= '{state: ST_IDLE, ms: '0, led: 1'b0, pend: 1'b0, mode: MODE_DIRECT};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign led_o = sq_q.led;

    p_direct_follow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == MODE_DIRECT) |=> (led_o == $past(act_i)))
        else $error("direct mode does not follow activity");

    p_stretch_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == MODE_STRETCH && act_i) |=> led_o)
        else $error("stretch activity did not light LED");

    p_blink_start_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mode_i == MODE_FAST || mode_i == MODE_SLOW) && same_mode
         && sq_q.state == ST_IDLE && act_i) |=> led_o)
        else $error("blink did not start from idle");

    p_switch_dark_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!same_mode && mode_i != MODE_DIRECT && !act_i) |=> !led_o)
        else $error("mode change left LED lit");

    p_ms_range_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sq_q.state != ST_IDLE) |-> (sq_q.ms <= MSW'(MAX_MS - 1)))
        else $error("millisecond count out of range");

endmodule

// File: rtl/led_activity_drv.sv
module led_activity_drv
    import led_act_pkg::*;
#(
    parameter int CLKS_PER_MS = 25000,
    parameter int HOLD_MS     = 42,
    parameter int FAST_MS     = 42,
    parameter int SLOW_MS     = 500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic act_i,
    input  logic str_pin_i,
    input  logic blink_pin_i,
    input  logic str_reg_i,
    input  logic blink_reg_i,
    output logic led_o
);

    led_mode_e mode;
    logic      tick;
    logic      clr;

    led_act_mode u_mode (
        .str_pin_i   (str_pin_i),
        .blink_pin_i (blink_pin_i),
        .str_reg_i   (str_reg_i),
        .blink_reg_i (blink_reg_i),
        .mode_o      (mode)
    );

    led_act_prescale #(
        .CLKS_PER_MS (CLKS_PER_MS)
    ) u_prescale (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr),
        .tick_o (tick)
    );

    led_act_seq #(
        .HOLD_MS (HOLD_MS),
        .FAST_MS (FAST_MS),
        .SLOW_MS (SLOW_MS)
    ) u_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mode_i (mode),
        .act_i  (act_i),
        .tick_i (tick),
        .clr_o  (clr),
        .led_o  (led_o)
    );

endmodule

// File: tb/led_activity_drv_tb.sv
module led_activity_drv_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CPM  = 2;
    localparam int HOLD = 42 * CPM;
    localparam int FAST = 42 * CPM;
    localparam int SLOW = 500 * CPM;

    // {str_pin, blink_pin, str_reg, blink_reg, led one clock after the strobe ends}
    localparam logic [4:0] VEC [0:7] = '{
        5'b0000_0, 5'b1000_1, 5'b0010_1, 5'b0100_1,
        5'b0001_1, 5'b1010_1, 5'b0101_1, 5'b1111_1
    };

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic act_i = 1'b0;
    logic str_pin_i = 1'b0;
    logic blink_pin_i = 1'b0;
    logic str_reg_i = 1'b0;
    logic blink_reg_i = 1'b0;
    logic led_o;
    int   tests = 0;
    int   fails = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    led_activity_drv #(.CLKS_PER_MS(CPM)) dut_i (
        .clk_i (clk), .rst_i (rst_i), .act_i (act_i),
        .str_pin_i (str_pin_i), .blink_pin_i (blink_pin_i),
        .str_reg_i (str_reg_i), .blink_reg_i (blink_reg_i),
        .led_o (led_o)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string req, input string what);
        tests++;
        if (led_o !== exp) begin
            fails++;
            $display("FAIL %s %s: led got %0b expected %0b", req, what, led_o, exp);
        end
    endtask

    task automatic pulse();
        act_i = 1'b1;
        wait_n(1);
        act_i = 1'b0;
    endtask

    task automatic set_en(input logic [3:0] en);
        {str_pin_i, blink_pin_i, str_reg_i, blink_reg_i} = en;
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        wait_n(2);
        rst_i = 1'b0;
    endtask

    initial begin
        wait_n(3);
        chk(1'b0, "R9", "led low in reset");
        rst_i = 1'b0;

        foreach (VEC[i]) begin
            set_en(VEC[i][4:1]);
            do_reset();
            pulse();
            chk(1'b1, (VEC[i][4:1] == 4'b0) ? "R3" : "R1", "lit after strobe");
            wait_n(1);
            chk(VEC[i][0], (VEC[i][3] | VEC[i][1]) ? "R2" : "R3", "one clock after strobe");
        end

        // R4: exact hold length
        set_en(4'b1000);
        do_reset();
        pulse();
        wait_n(HOLD - 1);
        chk(1'b1, "R4", "last held clock");
        wait_n(1);
        chk(1'b0, "R4", "falls after hold");

        // R5: retrigger restarts window
        pulse();
        wait_n(40);
        pulse();
        wait_n(HOLD - 1);
        chk(1'b1, "R5", "held past original deadline");
        wait_n(1);
        chk(1'b0, "R5", "falls at restarted deadline");

        // R6 / R8: fast blink, single pair then idle
        set_en(4'b0001);
        do_reset();
        pulse();
        wait_n(FAST - 1);
        chk(1'b1, "R6", "end of high phase");
        wait_n(1);
        chk(1'b0, "R6", "low phase start");
        wait_n(FAST - 1);
        chk(1'b0, "R6", "end of low phase");
        wait_n(12);
        chk(1'b0, "R8", "stays dark without activity");

        // R8: pending activity starts another pair
        pulse();
        wait_n(50);
        pulse();
        wait_n(FAST - 1 - 51);
        chk(1'b1, "R8", "first high phase end");
        wait_n(1);
        chk(1'b0, "R8", "first low phase");
        wait_n(FAST);
        chk(1'b1, "R8", "second pair starts");
        wait_n(FAST);
        chk(1'b0, "R8", "second low phase");
        wait_n(FAST + 5);
        chk(1'b0, "R8", "idle after second pair");

        // R7: slow blink with both enables
        set_en(4'b0110);
        do_reset();
        pulse();
        wait_n(FAST);
        chk(1'b1, "R7", "still high past fast length");
        wait_n(SLOW - 1 - FAST);
        chk(1'b1, "R7", "end of slow high");
        wait_n(1);
        chk(1'b0, "R7", "slow low phase");
        wait_n(SLOW - 1);
        chk(1'b0, "R7", "end of slow low");

        // R10: mode change drops the running blink
        set_en(4'b0001);
        pulse();
        wait_n(20);
        chk(1'b1, "R10", "blink running before change");
        set_en(4'b1000);
        wait_n(1);
        chk(1'b0, "R10", "dark after mode change");

        // R9: reset mid-hold, then full hold
        pulse();
        wait_n(10);
        rst_i = 1'b1;
        wait_n(1);
        chk(1'b0, "R9", "reset clears lit LED");
        rst_i = 1'b0;
        wait_n(3);
        pulse();
        wait_n(HOLD - 1);
        chk(1'b1, "R9", "full hold after reset");
        wait_n(1);
        chk(1'b0, "R9", "hold ends after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule